// File: doc/BRIEF.md
# Adaptive Interrupt Holdoff Counter

This block sits next to the interrupt logic of a pipelined processor and keeps the core from accepting a new interrupt too soon after one has been deferred. An interrupt can be deferred because an instruction already in flight switched interrupts off. If the core then took the next request at once, it could keep flushing and refetching handler code and never reach the code that turned interrupts off. On a deferral the block loads a holdoff counter and masks the raw request until that counter drains to zero. The counter only steps down on cycles where the front end of the pipeline makes progress, so the holdoff is measured in fetched work and not in clock cycles.

The value loaded on a deferral is an adaptive base. It starts at a minimum and gains one each time the commit stage sees a pending interrupt that must be deferred again. Executing an interrupt-enable instruction drops it back to the minimum. If the base is already at the stuck limit and the commit stage defers once more, the block gives up and raises a one-cycle stuck-interrupt exception pulse. After that pulse the base starts again from the minimum.

Top module: `irq_holdoff`

## Requirements
- R1: Synchronous active-high reset sets the holdoff counter to zero and the base to MIN_RELOAD (default 10). After reset, `irq_accept` follows `irq_raw & irq_en`, and `stuck_exc` is low.
- R2: When `defer_evt` is high at a clock edge, the counter loads the base value held before that edge. The load takes priority over a decrement in the same cycle.
- R3: The counter goes down by one only at an edge where `fe_advance` is high, `defer_evt` is low and the counter is non-zero. Otherwise it holds its value, so it never wraps below zero.
- R4: `irq_accept` is combinational and equals `irq_raw & irq_en & (counter == 0)`.
- R5: At an edge where `commit_irq_seen` is high, `ien_exec` is low and the base is below STUCK_LIMIT (default 1000), the base rises by exactly one.
- R6: At an edge where `ien_exec` is high, the base returns to MIN_RELOAD. This overrides a `commit_irq_seen` in the same cycle.
- R7: At an edge where `commit_irq_seen` is high, `ien_exec` is low and the base equals STUCK_LIMIT, `stuck_exc` is high for exactly the following cycle and the base returns to MIN_RELOAD. The base never exceeds STUCK_LIMIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| defer_evt | input | 1 | An interrupt was deferred by an in-flight disable; loads the holdoff |
| fe_advance | input | 1 | Front end advanced this cycle; allows one decrement |
| commit_irq_seen | input | 1 | Commit stage saw a pending interrupt that is deferred again |
| ien_exec | input | 1 | An interrupt-enable instruction executed |
| irq_raw | input | 1 | Raw interrupt request |
| irq_en | input | 1 | Interrupts currently enabled |
| irq_accept | output | 1 | Gated acceptance of the request |
| stuck_exc | output | 1 | One-cycle stuck-interrupt exception pulse |

## Verification
The bench drives a deferral with no front-end progress. A design that counted clocks instead of progress would open `irq_accept` early. It also loads the counter on a cycle that also advances. Decrementing first would leave the counter one short and release the request a cycle too soon. The bench then drives enough commit observations to walk the base all the way to the limit. A design that wrapped, tripped one step early or late, or kept the base at the limit after the pulse would show a misplaced or missing `stuck_exc`, or a wrong holdoff length on the next deferral. Interrupt-enable and commit arriving together check that the reset to the minimum wins.

// File: rtl/irq_holdoff_pkg.sv
package irq_holdoff_pkg;

    localparam int DEF_MIN_RELOAD  = 10;
    localparam int DEF_STUCK_LIMIT = 1000;

    typedef enum logic [1:0] {
        BASE_KEEP = 2'd0,
        BASE_GROW = 2'd1,
        BASE_MIN  = 2'd2,
        BASE_TRIP = 2'd3
    } base_act_e;

    typedef struct packed {
        logic ien;
        logic commit;
        logic at_limit;
    } base_evt_t;

    typedef enum logic [1:0] {
        CNT_KEEP = 2'd0,
        CNT_LOAD = 2'd1,
        CNT_STEP = 2'd2
    } cnt_act_e;

    function automatic base_act_e base_decide(input base_evt_t e);
        if (e.ien)
            return BASE_MIN;
        else if (e.commit && e.at_limit)
            return BASE_TRIP;
        else if (e.commit)
            return BASE_GROW;
        else
            return BASE_KEEP;
    endfunction

    function automatic cnt_act_e cnt_decide(input logic load, input logic adv,
                                            input logic is_zero);
        if (load)
            return CNT_LOAD;
        else if (adv && !is_zero)
            return CNT_STEP;
        else
            return CNT_KEEP;
    endfunction

endpackage

// File: rtl/irq_holdoff_base.sv
module irq_holdoff_base
    import irq_holdoff_pkg::*;
#(
    parameter int MIN_RELOAD  = DEF_MIN_RELOAD,
    parameter int STUCK_LIMIT = DEF_STUCK_LIMIT,
    parameter int CNT_W       = $clog2(STUCK_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit_irq_seen,
    input  logic             ien_exec,
    output logic [CNT_W-1:0] base_val,
    output logic             trip_pulse
);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_RELOAD);
    localparam logic [CNT_W-1:0] LIM_V = CNT_W'(STUCK_LIMIT);

    logic [CNT_W-1:0] base_q;
    logic             trip_q;
    base_evt_t        evt;
    base_act_e        act;

    always_comb begin
        evt.ien      = ien_exec;
        evt.commit   = commit_irq_seen;
        evt.at_limit = (base_q >= LIM_V);
        act          = base_decide(evt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= MIN_V;
            trip_q <= 1'b0;
        end else begin
            trip_q <= (act == BASE_TRIP);
            unique case (act)
                BASE_GROW: base_q <= base_q + 1'b1;
                BASE_MIN,
                BASE_TRIP: base_q <= MIN_V;
                default:   base_q <= base_q;
            endcase
        end
    end

    assign base_val   = base_q;
    assign trip_pulse = trip_q;
endmodule

// File: rtl/irq_holdoff_cnt.sv
module irq_holdoff_cnt
    import irq_holdoff_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             advance,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             drained
);
    logic [CNT_W-1:0] cnt_q;
    logic             zero;
    cnt_act_e         act;

    always_comb begin
        zero = (cnt_q == '0);
        act  = cnt_decide(load, advance, zero);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (act)
                CNT_LOAD: cnt_q <= load_val;
                CNT_STEP: cnt_q <= cnt_q - 1'b1;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    assign count   = cnt_q;
    assign drained = zero;
endmodule

// File: rtl/irq_holdoff.sv
module irq_holdoff
    import irq_holdoff_pkg::*;
#(
    parameter int MIN_RELOAD  = DEF_MIN_RELOAD,
    parameter int STUCK_LIMIT = DEF_STUCK_LIMIT
) (
    input  logic clk,
    input  logic rst,
    input  logic defer_evt,
    input  logic fe_advance,
    input  logic commit_irq_seen,
    input  logic ien_exec,
    input  logic irq_raw,
    input  logic irq_en,
    output logic irq_accept,
    output logic stuck_exc
);
    localparam int CNT_W = $clog2(STUCK_LIMIT + 1);

    logic [CNT_W-1:0] base_val;
    logic [CNT_W-1:0] hold_cnt;
    logic             hold_zero;

    irq_holdoff_base #(
        .MIN_RELOAD (MIN_RELOAD),
        .STUCK_LIMIT(STUCK_LIMIT),
        .CNT_W      (CNT_W)
    ) u_base (
        .clk            (clk),
        .rst            (rst),
        .commit_irq_seen(commit_irq_seen),
        .ien_exec       (ien_exec),
        .base_val       (base_val),
        .trip_pulse     (stuck_exc)
    );

    irq_holdoff_cnt #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .load    (defer_evt),
        .advance (fe_advance),
        .load_val(base_val),
        .count   (hold_cnt),
        .drained (hold_zero)
    );

    assign irq_accept = irq_raw & irq_en & hold_zero;
endmodule

// File: rtl/irq_holdoff_chk.sv
module irq_holdoff_chk #(
    parameter int MIN_RELOAD  = 10,
    parameter int STUCK_LIMIT = 1000,
    parameter int CNT_W       = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             defer_evt,
    input logic             fe_advance,
    input logic             commit_irq_seen,
    input logic             ien_exec,
    input logic             irq_accept,
    input logic             stuck_exc,
    input logic [CNT_W-1:0] base_val,
    input logic [CNT_W-1:0] hold_cnt
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (hold_cnt == '0 && base_val == CNT_W'(MIN_RELOAD) && !stuck_exc));

    // R2
    load_prio_chk: assert property (@(posedge clk) disable iff (rst)
        defer_evt |=> hold_cnt == $past(base_val));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!defer_evt && !fe_advance) |=> $stable(hold_cnt));

    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (!defer_evt && fe_advance && hold_cnt != '0) |=> hold_cnt == $past(hold_cnt) - 1'b1);

    // R4
    mask_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_cnt != '0) |-> !irq_accept);

    // R5
    grow_chk: assert property (@(posedge clk) disable iff (rst)
        (commit_irq_seen && !ien_exec && base_val < CNT_W'(STUCK_LIMIT))
            |=> base_val == $past(base_val) + 1'b1);

    // R6
    ien_min_chk: assert property (@(posedge clk) disable iff (rst)
        ien_exec |=> (base_val == CNT_W'(MIN_RELOAD) && !stuck_exc));

    // R7
    trip_chk: assert property (@(posedge clk) disable iff (rst)
        (commit_irq_seen && !ien_exec && base_val == CNT_W'(STUCK_LIMIT))
            |=> (stuck_exc && base_val == CNT_W'(MIN_RELOAD)));

    // R7
    pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
        stuck_exc |=> !stuck_exc);

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        base_val <= CNT_W'(STUCK_LIMIT));
endmodule

bind irq_holdoff irq_holdoff_chk #(
    .MIN_RELOAD (MIN_RELOAD),
    .STUCK_LIMIT(STUCK_LIMIT),
    .CNT_W      (CNT_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .defer_evt      (defer_evt),
    .fe_advance     (fe_advance),
    .commit_irq_seen(commit_irq_seen),
    .ien_exec       (ien_exec),
    .irq_accept     (irq_accept),
    .stuck_exc      (stuck_exc),
    .base_val       (base_val),
    .hold_cnt       (hold_cnt)
);

// File: tb/irq_holdoff_bench.sv
module irq_holdoff_bench;
    localparam int MINR = 10;
    localparam int LIM  = 1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic defer_evt = 0, fe_advance = 0, commit_irq_seen = 0, ien_exec = 0;
    logic irq_raw = 0, irq_en = 0;
    logic irq_accept, stuck_exc;

    int tests = 0;
    int fails = 0;
    int m_base, m_cnt;
    bit m_exc;
    bit done = 0;

    always #10 clk = ~clk;

    irq_holdoff #(.MIN_RELOAD(MINR), .STUCK_LIMIT(LIM)) u_irq_holdoff (
        .clk(clk), .rst(rst), .defer_evt(defer_evt), .fe_advance(fe_advance),
        .commit_irq_seen(commit_irq_seen), .ien_exec(ien_exec),
        .irq_raw(irq_raw), .irq_en(irq_en),
        .irq_accept(irq_accept), .stuck_exc(stuck_exc)
    );

    task automatic check(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0b expected %0b", req, $time, act, exp);
        end
    endtask

    // One cycle: apply inputs after the falling edge, compare against the model,
    // advance the model, then let the design take its rising edge.
    task automatic step(input string req, input bit d, input bit a, input bit c,
                        input bit i, input bit r, input bit e);
        int nb;
        bit nx;
        defer_evt = d; fe_advance = a; commit_irq_seen = c; ien_exec = i;
        irq_raw = r; irq_en = e;
        #1;
        check({req, "/R4 accept"}, irq_accept, r && e && (m_cnt == 0));
        check({req, "/R7 exc"}, stuck_exc, m_exc);
        nb = m_base; nx = 0;
        if (i) nb = MINR;
        else if (c && m_base >= LIM) begin nb = MINR; nx = 1; end
        else if (c) nb = m_base + 1;
        if (d) m_cnt = m_base;
        else if (a && m_cnt != 0) m_cnt = m_cnt - 1;
        m_base = nb; m_exc = nx;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Deferral then drain with raw request asserted; counts cycles to accept.
    task automatic drain_probe(input string req, input int expect_len);
        int n;
        step(req, 1, 0, 0, 0, 1, 1);
        n = 0;
        while (!irq_accept && n < 2000) begin
            step(req, 0, 1, 0, 0, 1, 1);
            n++;
        end
        tests++;
        if (n != expect_len) begin
            fails++;
            $display("FAIL %s holdoff length: actual %0d expected %0d", req, n, expect_len);
        end
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        m_base = MINR; m_cnt = 0; m_exc = 0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        // R1: reset state, accept follows raw & en
        step("R1", 0, 0, 0, 0, 1, 1);
        step("R1", 0, 0, 0, 0, 1, 0);
        step("R1", 0, 0, 0, 0, 0, 1);
        // R2/R3: load of MIN, then drain only on advance
        drain_probe("R2", MINR);
        step("R3", 1, 1, 0, 0, 1, 1);
        for (int k = 0; k < 20; k++) step("R3 stall", 0, 0, 0, 0, 1, 1);
        check("R3 no-advance holds mask", irq_accept, 1'b0);
        for (int k = 0; k < MINR + 2; k++) step("R3", 0, 1, 0, 0, 1, 1);
        // R5: growth by commit observations
        for (int k = 0; k < 5; k++) step("R5", 0, 0, 1, 0, 0, 0);
        drain_probe("R5", MINR + 5);
        // R6: enable wins over commit in same cycle
        step("R6", 0, 0, 1, 1, 0, 0);
        drain_probe("R6", MINR);
        // R7: walk to limit and trip
        for (int k = 0; k < LIM - MINR; k++) step("R7 grow", 0, 0, 1, 0, 0, 0);
        drain_probe("R7 at limit", LIM);
        step("R7 trip", 0, 0, 1, 0, 0, 0);
        check("R7 pulse", stuck_exc, 1'b1);
        step("R7 after", 0, 0, 0, 0, 0, 0);
        drain_probe("R7 back to min", MINR);
        // Mixed traffic compared against the model every cycle
        for (int k = 0; k < 4000; k++) begin
            int rv;
            rv = $urandom_range(0, 99);
            step("MIX", rv < 8, $urandom_range(0, 1) == 1, rv > 60,
                 rv == 50, $urandom_range(0, 1) == 1, $urandom_range(0, 3) != 0);
        end
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_base = MINR; m_cnt = 0; m_exc = 0;
        step("R1 re-reset", 0, 0, 0, 0, 1, 1);
        drain_probe("R1 re-reset min", MINR);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule